// File: doc/BRIEF.md
# SMT Commit Thread Selector

This block picks the hardware thread that may retire its reorder-buffer head in a multithreaded out-of-order core. For each thread it takes a three-bit status code, a head-ready flag, a buffer-empty flag, an active flag and the sequence number of the head entry. It answers with a grant flag and a thread index. A static policy input selects one of two arbitration schemes.

The first scheme is round-robin. It walks a registered priority list, and the thread that is granted moves to the tail. The second scheme is oldest-ready, which grants the qualifying thread with the smallest head sequence number. When exactly one thread is active, a bypass returns that thread whenever its status allows it.

The answer is combinational from the inputs and the list. The commit logic raises `take` in the cycle it actually uses a grant. The list update is registered on that clock edge, and the next select sees it.

Top module: `smt_commit_picker`

## Requirements
- R1: After reset the round-robin priority list holds the thread indices in ascending order, so with every thread eligible the first round-robin grant is thread 0.
- R2: `policy` encoding: 2'd1 selects round-robin; 2'd0 (aggressive), 2'd2 (oldest-ready) and 2'd3 all behave as oldest-ready.
- R3: Status encoding: 0 idle, 1 running, 2 squashing, 3 trap pending, 4 fetch-trap pending. Under oldest-ready a thread qualifies only if it is active, not empty, head-ready, and its status is 0, 1 or 4.
- R4: Under oldest-ready the grant goes to the qualifying thread with the smallest head sequence number. On equal sequence numbers the lower thread index wins.
- R5: Under round-robin a thread qualifies only if it is active, head-ready, and its status is 0 or 1. The grant goes to the qualifying thread that stands earliest in the priority list, and sequence numbers are ignored.
- R6: A round-robin grant taken (`pick_valid` and `take` both high) moves the grantee to the tail of the list. Threads ahead of it keep their positions, and threads behind it move up one place. The new order is used from the next cycle.
- R7: The priority list does not change in a cycle without `take`, without a grant, under an oldest-ready policy code, or under the single-thread bypass.
- R8: When exactly one bit of `active` is set, that thread is granted under any policy if its status is 0, 1 or 4, regardless of its ready and empty flags. With any other status, no grant is made.
- R9: When no thread qualifies, `pick_valid` is 0 and `pick_tid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy | input | 2 | Arbitration policy code |
| active | input | NTHR | Per-thread active flag |
| status | input | 3*NTHR | Per-thread status code, thread t at bits [3t+2:3t] |
| head_ready | input | NTHR | Per-thread head-ready flag |
| rob_empty | input | NTHR | Per-thread buffer-empty flag |
| head_seq | input | SEQW*NTHR | Per-thread head sequence number, thread t at bits [SEQW*t +: SEQW] |
| take | input | 1 | Commit slot consumed the current grant |
| pick_valid | output | 1 | A thread is granted |
| pick_tid | output | TW | Granted thread index |

## Verification
Granting a thread and rotating the priority list can fall in the same cycle. The grant is computed from the old list, and the rotated list takes effect only at the clock edge. The bench provokes this with back-to-back taken grants under changing ready masks, including several grants in a row to the same thread. It judges each cycle's grant against a queue model held in the bench, so any rotation that leaks into the current cycle, or that misplaces a skipped thread, shows up in the very next pick.

// File: rtl/smt_commit_picker.sv
module smt_commit_picker #(
  parameter int NTHR = 4,
  parameter int SEQW = 16,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           policy,
  input  logic [NTHR-1:0]      active,
  input  logic [3*NTHR-1:0]    status,
  input  logic [NTHR-1:0]      head_ready,
  input  logic [NTHR-1:0]      rob_empty,
  input  logic [SEQW*NTHR-1:0] head_seq,
  input  logic                 take,
  output logic                 pick_valid,
  output logic [TW-1:0]        pick_tid
);
  localparam logic [2:0] ST_IDLE = 3'd0;
  localparam logic [2:0] ST_RUN  = 3'd1;
  localparam logic [2:0] ST_FTP  = 3'd4;
  localparam logic [1:0] POL_RR  = 2'd1;

  logic [NTHR-1:0][TW-1:0] prio_q, prio_d;
  logic [NTHR-1:0] ok_rr, ok_old, ok_solo;
  logic            solo, solo_ok, rr_mode, advance;
  logic [TW-1:0]   solo_tid;
  logic            rr_hit, old_hit;
  logic [TW-1:0]   rr_tid, rr_pos, old_tid;
  logic [SEQW-1:0] old_seq;

  assign rr_mode = (policy == POL_RR);
  assign solo    = ($countones(active) == 1);

  always_comb begin
    logic [2:0] st;
    for (int t = 0; t < NTHR; t++) begin
      st         = status[3*t +: 3];
      ok_rr[t]   = active[t] && head_ready[t] && (st == ST_IDLE || st == ST_RUN);
      ok_solo[t] = (st == ST_IDLE || st == ST_RUN || st == ST_FTP);
      ok_old[t]  = active[t] && !rob_empty[t] && head_ready[t] && ok_solo[t];
    end
  end

  always_comb begin
    solo_tid = '0;
    for (int t = 0; t < NTHR; t++)
      if (active[t]) solo_tid = TW'(t);
  end
  assign solo_ok = ok_solo[solo_tid];

  always_comb begin
    rr_hit = 1'b0;
    rr_pos = '0;
    rr_tid = '0;
    for (int p = 0; p < NTHR; p++)
      if (!rr_hit && ok_rr[prio_q[p]]) begin
        rr_hit = 1'b1;
        rr_pos = TW'(p);
        rr_tid = prio_q[p];
      end
  end

  always_comb begin
    old_hit = 1'b0;
    old_tid = '0;
    old_seq = '0;
    for (int t = 0; t < NTHR; t++)
      if (ok_old[t] && (!old_hit || head_seq[SEQW*t +: SEQW] < old_seq)) begin
        old_hit = 1'b1;
        old_tid = TW'(t);
        old_seq = head_seq[SEQW*t +: SEQW];
      end
  end

  assign pick_valid = solo ? solo_ok : (rr_mode ? rr_hit : old_hit);
  assign pick_tid   = !pick_valid ? '0 : (solo ? solo_tid : (rr_mode ? rr_tid : old_tid));

  assign advance = pick_valid && take && rr_mode && !solo;

  always_comb begin
    for (int p = 0; p < NTHR - 1; p++)
      prio_d[p] = (p < int'(rr_pos)) ? prio_q[p] : prio_q[p+1];
    prio_d[NTHR-1] = rr_tid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NTHR; p++) prio_q[p] <= TW'(p);
    end else if (advance) begin
      prio_q <= prio_d;
    end
  end

  logic [NTHR-1:0] seen;
  logic            beaten;
  always_comb begin
    seen   = '0;
    beaten = 1'b0;
    for (int p = 0; p < NTHR; p++) seen[prio_q[p]] = 1'b1;
    for (int t = 0; t < NTHR; t++)
      if (ok_old[t] && head_seq[SEQW*t +: SEQW] < head_seq[SEQW*pick_tid +: SEQW])
        beaten = 1'b1;
  end

  p_list_perm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seen == {NTHR{1'b1}});
  p_rr_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_valid && !solo && rr_mode) |-> (head_ready[pick_tid] && active[pick_tid]));
  p_old_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_valid && !solo && !rr_mode) |-> (head_ready[pick_tid] && !rob_empty[pick_tid]));
  p_oldest_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_valid && !solo && !rr_mode) |-> !beaten);
  p_tail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> prio_q[NTHR-1] == $past(pick_tid));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(prio_q));
  p_idle_tid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pick_valid |-> pick_tid == '0);
  p_solo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (solo && pick_valid) |-> active[pick_tid]);
endmodule

// File: tb/smt_commit_picker_tb_top.sv
module smt_commit_picker_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  policy = '0;
  logic [3:0]  active = '0;
  logic [11:0] status = '0;
  logic [3:0]  head_ready = '0;
  logic [3:0]  rob_empty = '0;
  logic [31:0] head_seq = '0;
  logic        take = 1'b0;
  logic        pick_valid;
  logic [1:0]  pick_tid;

  int applied = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  smt_commit_picker #(.NTHR(4), .SEQW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .policy(policy), .active(active), .status(status),
    .head_ready(head_ready), .rob_empty(rob_empty), .head_seq(head_seq),
    .take(take), .pick_valid(pick_valid), .pick_tid(pick_tid));

  typedef struct packed {
    logic [1:0]  pol;
    logic [3:0]  act;
    logic [11:0] st;
    logic [3:0]  rdy;
    logic [3:0]  emp;
    logic [31:0] seq;
    logic        ev;
    logic [1:0]  et;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 4'hF, 12'o1111, 4'hF, 4'h0, 32'h40302010, 1'b1, 2'd0}, // R4 smallest seq
    '{2'd2, 4'hF, 12'o1111, 4'hF, 4'h0, 32'h10300520, 1'b1, 2'd1}, // R4
    '{2'd2, 4'hF, 12'o1111, 4'hD, 4'h0, 32'h10300520, 1'b1, 2'd3}, // R3 not-ready skipped
    '{2'd0, 4'hF, 12'o1111, 4'hD, 4'h0, 32'h10300520, 1'b1, 2'd3}, // R2 aggressive
    '{2'd3, 4'hF, 12'o1111, 4'hD, 4'h0, 32'h10300520, 1'b1, 2'd3}, // R2 code 3
    '{2'd2, 4'hF, 12'o2111, 4'hF, 4'h0, 32'h01300520, 1'b1, 2'd1}, // R3 squashing skipped
    '{2'd2, 4'hF, 12'o4000, 4'hF, 4'h0, 32'h01300520, 1'b1, 2'd3}, // R3 fetch-trap ok
    '{2'd2, 4'hF, 12'o1111, 4'hF, 4'h0, 32'h07070909, 1'b1, 2'd2}, // R4 tie
    '{2'd2, 4'hF, 12'o1111, 4'hF, 4'h4, 32'h07070909, 1'b1, 2'd3}, // R3 empty skipped
    '{2'd2, 4'hF, 12'o1111, 4'h0, 4'h0, 32'h07070909, 1'b0, 2'd0}, // R9
    '{2'd2, 4'hF, 12'o3333, 4'hF, 4'h0, 32'h07070909, 1'b0, 2'd0}, // R9
    '{2'd1, 4'hF, 12'o1111, 4'hF, 4'h0, 32'h01020304, 1'b1, 2'd0}, // R5 seq ignored
    '{2'd1, 4'hF, 12'o1111, 4'hC, 4'h0, 32'h01020304, 1'b1, 2'd2}, // R5
    '{2'd1, 4'hF, 12'o4411, 4'hF, 4'h0, 32'h01020304, 1'b1, 2'd0}, // R5
    '{2'd1, 4'hF, 12'o4411, 4'hC, 4'h0, 32'h01020304, 1'b0, 2'd0}, // R5 fetch-trap not ok
    '{2'd1, 4'hA, 12'o1111, 4'hF, 4'h0, 32'h01020304, 1'b1, 2'd1}, // R5 inactive skipped
    '{2'd2, 4'h4, 12'o0411, 4'h0, 4'hF, 32'h01020304, 1'b1, 2'd2}, // R8
    '{2'd2, 4'h4, 12'o0211, 4'hF, 4'h0, 32'h01020304, 1'b0, 2'd0}, // R8 squashing
    '{2'd1, 4'h1, 12'o1110, 4'h0, 4'hF, 32'h01020304, 1'b1, 2'd0}, // R8 under rr
    '{2'd2, 4'h0, 12'o1111, 4'hF, 4'h0, 32'h01020304, 1'b0, 2'd0}  // R9 none active
  };

  task automatic drive(input logic [1:0] pol, input logic [3:0] act, input logic [11:0] st,
                       input logic [3:0] rdy, input logic [3:0] emp, input logic [31:0] seq,
                       input logic tk);
    @(negedge clk);
    policy = pol; active = act; status = st; head_ready = rdy;
    rob_empty = emp; head_seq = seq; take = tk;
    #1;
  endtask

  task automatic check(input logic ev, input logic [1:0] et, input string tag);
    applied++;
    if (pick_valid !== ev || pick_tid !== et) begin
      bad++;
      $display("FAIL %s: got valid=%0b tid=%0d, expected valid=%0b tid=%0d",
               tag, pick_valid, pick_tid, ev, et);
    end
  endtask

  int q [4];
  task automatic model_reset();
    for (int i = 0; i < 4; i++) q[i] = i;
  endtask

  task automatic rr_step(input logic [3:0] rdy, input string tag);
    int pos;
    int g;
    pos = -1;
    g = 0;
    for (int p = 0; p < 4; p++)
      if (pos < 0 && rdy[q[p]]) begin pos = p; g = q[p]; end
    drive(2'd1, 4'hF, 12'o1111, rdy, 4'h0, 32'h0, 1'b1);
    check(pos >= 0, (pos >= 0) ? 2'(g) : 2'd0, tag);
    if (pos >= 0) begin
      for (int p = pos; p < 3; p++) q[p] = q[p+1];
      q[3] = g;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset order and R9 idle outputs
    drive(2'd1, 4'hF, 12'o1111, 4'h0, 4'h0, 32'h0, 1'b0);
    check(1'b0, 2'd0, "R9 reset idle");
    drive(2'd1, 4'hF, 12'o1111, 4'hF, 4'h0, 32'h0, 1'b0);
    check(1'b1, 2'd0, "R1 first rr grant");

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].pol, VECS[i].act, VECS[i].st, VECS[i].rdy, VECS[i].emp, VECS[i].seq, 1'b0);
      check(VECS[i].ev, VECS[i].et, $sformatf("vector %0d (R2-R9 table)", i));
    end

    // R7: takes under oldest-ready, solo and with no grant leave the list alone
    drive(2'd2, 4'hF, 12'o1111, 4'hF, 4'h0, 32'h01020304, 1'b1);
    check(1'b1, 2'd3, "R7 oldest take");
    drive(2'd1, 4'h4, 12'o1111, 4'hF, 4'h0, 32'h0, 1'b1);
    check(1'b1, 2'd2, "R7 solo take");
    drive(2'd1, 4'hF, 12'o1111, 4'h0, 4'h0, 32'h0, 1'b1);
    check(1'b0, 2'd0, "R7 take without grant");
    drive(2'd1, 4'hF, 12'o1111, 4'hF, 4'h0, 32'h0, 1'b0);
    check(1'b1, 2'd0, "R7 list unchanged");

    // R6: rotation under changing ready masks, repeated grants to one thread
    model_reset();
    rr_step(4'hF, "R6 rot a");
    rr_step(4'hF, "R6 rot b");
    rr_step(4'h4, "R6 same thread 1");
    rr_step(4'h4, "R6 same thread 2");
    rr_step(4'h4, "R6 same thread 3");
    rr_step(4'hF, "R6 order after repeats a");
    rr_step(4'hF, "R6 order after repeats b");
    rr_step(4'h3, "R6 partial mask");
    rr_step(4'h8, "R6 single ready");
    rr_step(4'hF, "R6 order c");
    rr_step(4'hF, "R6 order d");
    rr_step(4'hF, "R6 order e");
    rr_step(4'h0, "R6 no ready");
    rr_step(4'hF, "R6 order f");

    // R1: reset restores ascending order
    @(negedge clk); rst_n = 1'b0; take = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    drive(2'd1, 4'hF, 12'o1111, 4'hF, 4'h0, 32'h0, 1'b1);
    check(1'b1, 2'd0, "R1 after re-reset");
    drive(2'd1, 4'hF, 12'o1111, 4'hF, 4'h0, 32'h0, 1'b1);
    check(1'b1, 2'd1, "R1 second grant");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule